// File: doc/BRIEF.md
# Transactional Token Conflict Tracker

This block decides, for a transactional memory, whether a transaction may touch a memory block. Every block owns a fixed number of tokens (`TOKENS`). A transactional read must hold at least one of them. A transactional write must hold all of them. When a request cannot be satisfied, it is reported as a conflict.

The block does not keep a full per-thread holder vector for each memory block. Instead it stores a compact summary per block: the number of tokens handed out, plus an owner thread id that is valid only when a single thread can be proven to hold them. Each successful acquisition emits a log record (block address, thread id, tokens taken). The requesting thread appends this record to its own software token log. When a transaction commits or aborts, the thread replays that log as release requests, which return the tokens.

A combinational query port exposes the summary of any block. Requests are accepted one per cycle. The response and the log record appear one clock after the request.

Top module: `token_meta_tracker`

## Requirements
- R1: After reset every block summary reads sum 0 with the owner flag clear. No response or log record is valid until a request arrives.
- R2: A read (req_op = 0) to a block with sum 0 is granted. The block becomes sum 1 with the requester as owner, and one log record with count 1 is emitted.
- R3: A read by a thread that is not a proven sole holder, to a block with 1 ≤ sum ≤ TOKENS-2, is granted. Sum increments, the owner flag clears, and count 1 is logged. The same read at sum TOKENS-1 is a conflict.
- R4: A read by the proven owner of a block with sum 1 or sum TOKENS is granted with no state change and no log record. A write (req_op = 1) by the proven owner of a block with sum TOKENS behaves the same way.
- R5: A write to a block with sum 0 is granted. The block becomes sum TOKENS owned by the requester, and count TOKENS is logged.
- R6: A write by the proven owner of a block with sum 1 upgrades it to sum TOKENS, keeps that owner, and logs count TOKENS-1.
- R7: Any other write is a conflict, as is a read to a block at sum TOKENS owned by another thread. A conflict changes no state and emits no log record.
- R8: A release (req_op = 2) with req_cnt ≤ sum is granted and subtracts req_cnt. The owner flag is always cleared, so after a release the owner is unknown, including when the new sum is 0. A release with req_cnt > sum is neither granted nor a conflict, and leaves the block unchanged. Releases emit no log record.
- R9: Every request (req_op = 3 is a no-op, neither granted nor conflict) yields rsp_valid exactly one cycle later. A log record carries the request's address and thread id. rsp_grant and rsp_conflict are never both high.
- R10: The query port reports sum, owner flag and owner id of q_addr combinationally, and already reflects a request in the cycle its response is valid. The owner flag can be set only when sum is 1 or TOKENS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 release, 3 no-op |
| req_addr | input | clog2(NUM_BLOCKS) | Block index |
| req_tid | input | TID_W | Requesting thread |
| req_cnt | input | clog2(TOKENS+1) | Tokens returned by a release |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | Request satisfied |
| rsp_conflict | output | 1 | Not enough tokens |
| log_valid | output | 1 | Log record strobe |
| log_addr | output | clog2(NUM_BLOCKS) | Block of the record |
| log_tid | output | TID_W | Thread whose log takes the record |
| log_cnt | output | clog2(TOKENS+1) | Tokens acquired |
| q_addr | input | clog2(NUM_BLOCKS) | Query block |
| q_sum | output | clog2(TOKENS+1) | Tokens held on the query block |
| q_owner_vld | output | 1 | Owner id is meaningful |
| q_owner | output | TID_W | Proven holder |

## Verification
The assertions hold the following on every cycle:
- a stored sum never exceeds TOKENS;
- an owner is only recorded at sum 1 or TOKENS;
- grant and conflict are exclusive;
- a log record only accompanies a grant and carries a count between 1 and TOKENS;
- each response follows a request by one cycle.

Whether the decision and the new summary are right for a given history needs a reference model. Examples are an upgrade that logs TOKENS-1, a sole reader re-reading without a count change, the read that would reach TOKENS, and an over-sized release. Only the bench scenarios, which track every block in a model, can show these.

// File: rtl/tok_pkg.sv
package tok_pkg;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_REL  = 2'd2,
    OP_NONE = 2'd3
  } tok_op_e;

endpackage

// File: rtl/tok_summary_store.sv
module tok_summary_store #(
  parameter int NUM_BLOCKS = 16,
  parameter int TOKENS     = 16,
  parameter int TID_W      = 3,
  parameter int ADDR_W     = 4,
  parameter int SUM_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SUM_W-1:0]  wr_sum,
  input  logic              wr_ov,
  input  logic [TID_W-1:0]  wr_own,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [SUM_W-1:0]  ra_sum,
  output logic              ra_ov,
  output logic [TID_W-1:0]  ra_own,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [SUM_W-1:0]  rb_sum,
  output logic              rb_ov,
  output logic [TID_W-1:0]  rb_own
);

  logic [SUM_W-1:0] sum_q [NUM_BLOCKS];
  logic [SUM_W-1:0] sum_d [NUM_BLOCKS];
  logic             ov_q  [NUM_BLOCKS];
  logic             ov_d  [NUM_BLOCKS];
  logic [TID_W-1:0] own_q [NUM_BLOCKS];
  logic [TID_W-1:0] own_d [NUM_BLOCKS];

  always_comb begin
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      sum_d[b] = sum_q[b];
      ov_d[b]  = ov_q[b];
      own_d[b] = own_q[b];
      if (wr_en && (wr_addr == ADDR_W'(b))) begin
        sum_d[b] = wr_sum;
        ov_d[b]  = wr_ov;
        own_d[b] = wr_own;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        sum_q[b] <= '0;
        ov_q[b]  <= 1'b0;
        own_q[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        sum_q[b] <= sum_d[b];
        ov_q[b]  <= ov_d[b];
        own_q[b] <= own_d[b];
      end
    end
  end

  assign ra_sum = sum_q[ra_addr];
  assign ra_ov  = ov_q[ra_addr];
  assign ra_own = own_q[ra_addr];
  assign rb_sum = sum_q[rb_addr];
  assign rb_ov  = ov_q[rb_addr];
  assign rb_own = own_q[rb_addr];

  // R8
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_sum <= SUM_W'(TOKENS)));

  // R10
  owner_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ov) |-> ((wr_sum == SUM_W'(1)) || (wr_sum == SUM_W'(TOKENS))));

endmodule

// File: rtl/tok_decide.sv
module tok_decide
  import tok_pkg::*;
#(
  parameter int TOKENS = 16,
  parameter int TID_W  = 3,
  parameter int SUM_W  = 5
) (
  input  tok_op_e          op,
  input  logic [TID_W-1:0] tid,
  input  logic [SUM_W-1:0] cnt,
  input  logic [SUM_W-1:0] cur_sum,
  input  logic             cur_ov,
  input  logic [TID_W-1:0] cur_own,
  output logic             grant,
  output logic             conflict,
  output logic             upd,
  output logic [SUM_W-1:0] nx_sum,
  output logic             nx_ov,
  output logic [TID_W-1:0] nx_own,
  output logic             log_en,
  output logic [SUM_W-1:0] log_cnt
);

  localparam logic [SUM_W-1:0] FULL     = SUM_W'(TOKENS);
  localparam logic [SUM_W-1:0] NEAR     = SUM_W'(TOKENS - 1);
  localparam logic [SUM_W-1:0] ONE      = SUM_W'(1);

  logic free_blk;
  logic self_sole;
  logic self_full;

  assign free_blk  = (cur_sum == '0);
  assign self_sole = cur_ov && (cur_own == tid) && (cur_sum == ONE);
  assign self_full = cur_ov && (cur_own == tid) && (cur_sum == FULL);

  always_comb begin
    grant    = 1'b0;
    conflict = 1'b0;
    upd      = 1'b0;
    nx_sum   = cur_sum;
    nx_ov    = cur_ov;
    nx_own   = cur_own;
    log_en   = 1'b0;
    log_cnt  = '0;
    unique case (op)
      OP_RD: begin
        if (free_blk) begin
          grant = 1'b1; upd = 1'b1;
          nx_sum = ONE; nx_ov = 1'b1; nx_own = tid;
          log_en = 1'b1; log_cnt = ONE;
        end else if (self_sole || self_full) begin
          grant = 1'b1;
        end else if ((cur_sum == FULL) || (cur_sum == NEAR)) begin
          conflict = 1'b1;
        end else begin
          grant = 1'b1; upd = 1'b1;
          nx_sum = cur_sum + ONE; nx_ov = 1'b0;
          log_en = 1'b1; log_cnt = ONE;
        end
      end
      OP_WR: begin
        if (free_blk) begin
          grant = 1'b1; upd = 1'b1;
          nx_sum = FULL; nx_ov = 1'b1; nx_own = tid;
          log_en = 1'b1; log_cnt = FULL;
        end else if (self_full) begin
          grant = 1'b1;
        end else if (self_sole) begin
          grant = 1'b1; upd = 1'b1;
          nx_sum = FULL; nx_ov = 1'b1; nx_own = tid;
          log_en = 1'b1; log_cnt = NEAR;
        end else begin
          conflict = 1'b1;
        end
      end
      OP_REL: begin
        if (cnt <= cur_sum) begin
          grant = 1'b1; upd = 1'b1;
          nx_sum = cur_sum - cnt; nx_ov = 1'b0;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/token_meta_tracker.sv
module token_meta_tracker
  import tok_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int TOKENS     = 16,
  parameter int TID_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [1:0]                   req_op,
  input  logic [$clog2(NUM_BLOCKS)-1:0] req_addr,
  input  logic [TID_W-1:0]             req_tid,
  input  logic [$clog2(TOKENS+1)-1:0]  req_cnt,
  output logic                         rsp_valid,
  output logic                         rsp_grant,
  output logic                         rsp_conflict,
  output logic                         log_valid,
  output logic [$clog2(NUM_BLOCKS)-1:0] log_addr,
  output logic [TID_W-1:0]             log_tid,
  output logic [$clog2(TOKENS+1)-1:0]  log_cnt,
  input  logic [$clog2(NUM_BLOCKS)-1:0] q_addr,
  output logic [$clog2(TOKENS+1)-1:0]  q_sum,
  output logic                         q_owner_vld,
  output logic [TID_W-1:0]             q_owner
);

  localparam int ADDR_W = $clog2(NUM_BLOCKS);
  localparam int SUM_W  = $clog2(TOKENS + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sq;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  logic [SUM_W-1:0] cur_sum, nx_sum, dec_log_cnt;
  logic             cur_ov, nx_ov;
  logic [TID_W-1:0] cur_own, nx_own;
  logic             dec_grant, dec_conflict, dec_upd, dec_log;
  tok_op_e          op_e;

  assign op_e = tok_op_e'(req_op);

  tok_summary_store #(
    .NUM_BLOCKS(NUM_BLOCKS), .TOKENS(TOKENS), .TID_W(TID_W),
    .ADDR_W(ADDR_W), .SUM_W(SUM_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (req_valid && dec_upd),
    .wr_addr (req_addr),
    .wr_sum  (nx_sum),
    .wr_ov   (nx_ov),
    .wr_own  (nx_own),
    .ra_addr (req_addr),
    .ra_sum  (cur_sum),
    .ra_ov   (cur_ov),
    .ra_own  (cur_own),
    .rb_addr (q_addr),
    .rb_sum  (q_sum),
    .rb_ov   (q_owner_vld),
    .rb_own  (q_owner)
  );

  tok_decide #(.TOKENS(TOKENS), .TID_W(TID_W), .SUM_W(SUM_W)) u_decide (
    .op       (op_e),
    .tid      (req_tid),
    .cnt      (req_cnt),
    .cur_sum  (cur_sum),
    .cur_ov   (cur_ov),
    .cur_own  (cur_own),
    .grant    (dec_grant),
    .conflict (dec_conflict),
    .upd      (dec_upd),
    .nx_sum   (nx_sum),
    .nx_ov    (nx_ov),
    .nx_own   (nx_own),
    .log_en   (dec_log),
    .log_cnt  (dec_log_cnt)
  );

  // response and log record registers
  logic              rsp_valid_d, rsp_grant_d, rsp_conflict_d, log_valid_d;
  logic              log_ce;
  logic [ADDR_W-1:0] log_addr_d;
  logic [TID_W-1:0]  log_tid_d;
  logic [SUM_W-1:0]  log_cnt_d;

  always_comb begin
    rsp_valid_d    = req_valid;
    rsp_grant_d    = req_valid && dec_grant;
    rsp_conflict_d = req_valid && dec_conflict;
    log_valid_d    = req_valid && dec_log;
    log_ce         = req_valid && dec_log;
    log_addr_d     = log_addr;
    log_tid_d      = log_tid;
    log_cnt_d      = log_cnt;
    if (log_ce) begin
      log_addr_d = req_addr;
      log_tid_d  = req_tid;
      log_cnt_d  = dec_log_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid    <= 1'b0;
      rsp_grant    <= 1'b0;
      rsp_conflict <= 1'b0;
      log_valid    <= 1'b0;
      log_addr     <= '0;
      log_tid      <= '0;
      log_cnt      <= '0;
    end else begin
      rsp_valid    <= rsp_valid_d;
      rsp_grant    <= rsp_grant_d;
      rsp_conflict <= rsp_conflict_d;
      log_valid    <= log_valid_d;
      log_addr     <= log_addr_d;
      log_tid      <= log_tid_d;
      log_cnt      <= log_cnt_d;
    end
  end

  // R9
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rsp_grant && rsp_conflict));

  // R7
  no_log_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_conflict |-> !log_valid);

  // R9
  log_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    log_valid |-> (rsp_valid && rsp_grant));

  // R5
  log_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    log_valid |-> ((log_cnt != '0) && (log_cnt <= SUM_W'(TOKENS))));

  // R9
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> rsp_valid);

endmodule

// File: tb/token_meta_tracker_tb.sv
module token_meta_tracker_tb;

  localparam int NB   = 16;
  localparam int TK   = 16;
  localparam int TW   = 3;
  localparam int AW   = $clog2(NB);
  localparam int SW   = $clog2(TK + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [TW-1:0] req_tid;
  logic [SW-1:0] req_cnt;
  logic          rsp_valid, rsp_grant, rsp_conflict, log_valid;
  logic [AW-1:0] log_addr;
  logic [TW-1:0] log_tid;
  logic [SW-1:0] log_cnt;
  logic [AW-1:0] q_addr;
  logic [SW-1:0] q_sum;
  logic          q_owner_vld;
  logic [TW-1:0] q_owner;

  always #2 clk = ~clk;

  token_meta_tracker #(.NUM_BLOCKS(NB), .TOKENS(TK), .TID_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_tid(req_tid), .req_cnt(req_cnt),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_conflict(rsp_conflict),
    .log_valid(log_valid), .log_addr(log_addr), .log_tid(log_tid),
    .log_cnt(log_cnt), .q_addr(q_addr), .q_sum(q_sum),
    .q_owner_vld(q_owner_vld), .q_owner(q_owner)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int m_sum [NB];
  bit m_ov  [NB];
  int m_own [NB];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected outcome from the requirements; updates the model
  task automatic model(input int op, input int a, input int t, input int c,
                       output bit g, output bit cf, output bit lg, output int lc,
                       output string tag);
    bit sole, full;
    g = 0; cf = 0; lg = 0; lc = 0; tag = "R9";
    sole = m_ov[a] && m_own[a] == t && m_sum[a] == 1;
    full = m_ov[a] && m_own[a] == t && m_sum[a] == TK;
    if (op == 0) begin
      if (m_sum[a] == 0) begin
        tag = "R2"; g = 1; lg = 1; lc = 1;
        m_sum[a] = 1; m_ov[a] = 1; m_own[a] = t;
      end else if (sole || full) begin
        tag = "R4"; g = 1;
      end else if (m_sum[a] == TK) begin
        tag = "R7"; cf = 1;
      end else if (m_sum[a] == TK - 1) begin
        tag = "R3"; cf = 1;
      end else begin
        tag = "R3"; g = 1; lg = 1; lc = 1;
        m_sum[a]++; m_ov[a] = 0;
      end
    end else if (op == 1) begin
      if (m_sum[a] == 0) begin
        tag = "R5"; g = 1; lg = 1; lc = TK;
        m_sum[a] = TK; m_ov[a] = 1; m_own[a] = t;
      end else if (full) begin
        tag = "R4"; g = 1;
      end else if (sole) begin
        tag = "R6"; g = 1; lg = 1; lc = TK - 1;
        m_sum[a] = TK;
      end else begin
        tag = "R7"; cf = 1;
      end
    end else if (op == 2) begin
      tag = "R8";
      if (c <= m_sum[a]) begin
        g = 1; m_sum[a] -= c; m_ov[a] = 0;
      end
    end
  endtask

  task automatic do_req(input int op, input int a, input int t, input int c);
    bit g, cf, lg; int lc; string tag;
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_addr = a[AW-1:0];
    req_tid = t[TW-1:0]; req_cnt = c[SW-1:0]; q_addr = a[AW-1:0];
    model(op, a, t, c, g, cf, lg, lc, tag);
    @(posedge clk);
    #1;
    chk(tag, "rsp_valid", int'(rsp_valid), 1);
    chk(tag, "grant", int'(rsp_grant), int'(g));
    chk(tag, "conflict", int'(rsp_conflict), int'(cf));
    chk(tag, "log_valid", int'(log_valid), int'(lg));
    if (lg) begin
      chk(tag, "log_cnt", int'(log_cnt), lc);
      chk("R9", "log_addr", int'(log_addr), a);
      chk("R9", "log_tid", int'(log_tid), t);
    end
    chk("R10", "q_sum", int'(q_sum), m_sum[a]);
    chk("R10", "q_owner_vld", int'(q_owner_vld), int'(m_ov[a]));
    if (m_ov[a]) chk("R10", "q_owner", int'(q_owner), m_own[a]);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin m_sum[b] = 0; m_ov[b] = 0; m_own[b] = 0; end
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd3; req_addr = '0;
    req_tid = '0; req_cnt = '0; q_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "log_valid", int'(log_valid), 0);
    for (int b = 0; b < NB; b++) begin
      q_addr = b[AW-1:0]; #1;
      chk("R1", "q_sum", int'(q_sum), 0);
      chk("R1", "q_owner_vld", int'(q_owner_vld), 0);
    end

    // directed: fill block 7 with readers up to TOKENS-1 (R2, R4, R3)
    do_req(0, 7, 0, 0);
    do_req(0, 7, 0, 0);
    for (int i = 0; i < TK - 2; i++) do_req(0, 7, (i % 2) + 1, 0);
    do_req(0, 7, 5, 0);            // R3 would reach TOKENS: conflict
    do_req(1, 7, 0, 0);            // R7 write with unknown owner
    do_req(2, 7, 0, TK);           // R8 oversize release rejected
    do_req(2, 7, 0, TK - 1);       // R8 back to 0
    do_req(1, 7, 2, 0);            // R5
    do_req(0, 7, 1, 0);            // R7 read against writer
    do_req(0, 7, 2, 0);            // R4 writer reads
    do_req(1, 7, 2, 0);            // R4 writer writes again
    do_req(2, 7, 2, TK);           // R8
    do_req(0, 7, 3, 0);            // R2
    do_req(1, 7, 3, 0);            // R6 upgrade
    do_req(1, 7, 4, 0);            // R7
    do_req(2, 7, 3, TK);
    do_req(0, 7, 1, 0);
    do_req(0, 7, 2, 0);
    do_req(1, 7, 1, 0);            // R7 two readers
    do_req(2, 7, 2, 1);            // R8 owner stays unknown at sum 1
    do_req(1, 7, 1, 0);            // R7 owner not proven
    do_req(3, 7, 1, 0);            // R9 no-op
    do_req(2, 7, 1, 0);            // R8 zero-count release

    // random traffic on blocks 0..3 with threads 0..2
    for (int i = 0; i < 600; i++) begin
      int op, a, t, c;
      op = int'($urandom % 10);
      op = (op < 4) ? 0 : (op < 7) ? 1 : (op < 9) ? 2 : 3;
      a  = int'($urandom % 4);
      t  = int'($urandom % 3);
      c  = int'($urandom % (m_sum[a] + 2));
      if (c > TK) c = TK;
      do_req(op, a, t, c);
    end

    @(negedge clk) req_valid = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R9", "idle rsp_valid", int'(rsp_valid), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule